// File: doc/BRIEF.md
# Privilege-filtered cycle counter

This block is a free-running cycle counter whose increment is gated, cycle by cycle, by a 32-bit filter word. On every clock the block looks at two inputs: the current privilege level, from 0 to 3, and whether the core is in the secure or the non-secure state. It tests them against pairs of filter bits and decides whether that cycle is counted. A global enable sits on top of the per-level decision. The filter keeps only the bits that belong to implemented levels. Every other bit reads as zero and ignores writes.

The filter is reached through a small memory-mapped debug port. The port answers each request one cycle later. The answer is an error when the core is unpowered, when a lock is held, when external access is refused, or when the offset does not match the filter's location. It is read-only while the software lock is set, and read-write otherwise. Parameters choose whether levels 2 and 3 and secure level 2 exist, and the width of the counter.

Top module: `pfc_cycle_counter`

## Requirements
- R1: After the core reset, `cycle_count` is 0 and the filter reads 0. Each cycle that is permitted adds exactly one, and each cycle that is not permitted leaves the count unchanged.
- R2: While `count_en` is low, the count holds, whatever the filter and level inputs are.
- R3: In the secure state, a level-1 cycle counts only when filter bit 31 is 0, and a level-0 cycle counts only when bit 30 is 0.
- R4: In the non-secure state, a level-1 cycle counts only when bit 29 equals bit 31, and a level-0 cycle counts only when bit 28 equals bit 30.
- R5: A non-secure level-2 cycle counts only when bit 27 is 1.
- R6: A secure level-2 cycle counts only when `sec_lvl2_on` is high and bit 24 differs from bit 27. Bit 24 reads as 0 while `sec_lvl2_on` is low.
- R7: A level-3 cycle counts only when bit 26 equals bit 31, whatever `cur_secure` is.
- R8: Bits 25 and 23:0 always read as 0, and writing ones to them has no effect. Bits that belong to levels absent by parameter also read as 0.
- R9: A request returns an error response (`dbg_resp` = 2'b10) and read data 0 when `core_pwr_on` is low, when `dbl_lock` or `os_lock` is high, when `ext_allow` is low, or when `dbg_addr` is not 0x47C. A write under any of these conditions leaves the filter unchanged.
- R10: With access allowed and `sw_lock` high, a write gets an OK response (2'b00) and leaves the filter unchanged, and a read returns the filter. With `sw_lock` low, a write updates the filter.
- R11: `dbg_ack` is high in the cycle after a request and low otherwise. A filter write governs the counting decision from the cycle after the edge that stores it.
- R12: Asserting `dbg_rst_n` clears only the debug port's response; it disturbs neither the filter nor the count.
- R13: The count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| dbg_rst_n | input | 1 | Debug-side reset, active low, clears the port response only |
| count_en | input | 1 | Global counter enable |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| cur_secure | input | 1 | 1 = secure state, 0 = non-secure |
| sec_lvl2_on | input | 1 | Secure level 2 enabled at run time |
| core_pwr_on | input | 1 | Core power is up |
| dbl_lock | input | 1 | Double lock held |
| os_lock | input | 1 | OS lock held |
| ext_allow | input | 1 | External debug access permitted |
| sw_lock | input | 1 | Software lock; makes the filter read-only |
| dbg_req | input | 1 | Debug access request, one cycle per access |
| dbg_we | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | ADDR_W | Byte offset of the access |
| dbg_wdata | input | 32 | Write data |
| dbg_ack | output | 1 | Response valid, one cycle after the request |
| dbg_resp | output | 2 | 2'b00 OK, 2'b10 error |
| dbg_rdata | output | 32 | Read data, 0 on write or on error |
| cycle_count | output | CNT_W | Cycle count |

## Verification
The bound checker covers the count behaviour on every cycle. The count steps by exactly one on a permitted cycle and otherwise holds. It stays frozen while the enable is low or while a level-3 cycle meets unequal control bits. The checker also covers the port behaviour. The acknowledge follows each request by one cycle. A faulted request always ends in an error. Reserved read bits are zero, and a write under the software lock leaves the stored filter unchanged. The remaining behaviours show only in the bench's scenarios. These are the pairwise equality tests for each level and state, the effect of the run-time secure level-2 switch, the read-back masks for different parameter sets, the write-to-effect latency, immunity to the debug reset, and the wrap of a narrow counter.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int FW = 32;

  // Filter bit positions; the counting rules compare these pairwise.
  localparam int B_L1_BLK = 31;
  localparam int B_L0_BLK = 30;
  localparam int B_NS1    = 29;
  localparam int B_NS0    = 28;
  localparam int B_NS2    = 27;
  localparam int B_L3     = 26;
  localparam int B_S2     = 24;

  localparam logic [FW-1:0] S2_MASK = FW'(1) << B_S2;

  typedef enum logic [1:0] {
    RSP_OK  = 2'b00,
    RSP_ERR = 2'b10
  } rsp_e;

  // Bits that hold state for a given set of implemented levels.
  function automatic logic [FW-1:0] impl_mask(input bit has2, input bit has3,
                                              input bit hass2);
    logic [FW-1:0] m;
    m = '0;
    m[B_L1_BLK] = 1'b1;
    m[B_L0_BLK] = 1'b1;
    if (has3) begin
      m[B_NS1] = 1'b1;
      m[B_NS0] = 1'b1;
      m[B_L3]  = 1'b1;
    end
    if (has2) m[B_NS2] = 1'b1;
    if (has2 && hass2) m[B_S2] = 1'b1;
    return m;
  endfunction

  // Per-level counting decision.
  function automatic logic level_permits(input logic [FW-1:0] f,
                                         input logic [1:0] lvl,
                                         input logic sec,
                                         input logic s2_live,
                                         input bit has2, input bit has3,
                                         input bit hass2);
    logic ok;
    case (lvl)
      2'd0:    ok = sec ? ~f[B_L0_BLK] : (f[B_NS0] == f[B_L0_BLK]);
      2'd1:    ok = sec ? ~f[B_L1_BLK] : (f[B_NS1] == f[B_L1_BLK]);
      2'd2:    ok = sec ? (has2 && hass2 && s2_live && (f[B_S2] != f[B_NS2]))
                        : (has2 && f[B_NS2]);
      default: ok = has3 && (f[B_L3] == f[B_L1_BLK]);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pfc_filter_reg.sv
module pfc_filter_reg #(
  parameter bit HAS_LVL2     = 1'b1,
  parameter bit HAS_LVL3     = 1'b1,
  parameter bit HAS_SEC_LVL2 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [pfc_pkg::FW-1:0] wr_data,
  input  logic                   s2_live,
  output logic [pfc_pkg::FW-1:0] filt_q,
  output logic [pfc_pkg::FW-1:0] rd_val
);
  import pfc_pkg::*;

  localparam logic [FW-1:0] KEEP = impl_mask(HAS_LVL2, HAS_LVL3, HAS_SEC_LVL2);

  for (genvar b = 0; b < FW; b++) begin : g_bit
    if (KEEP[b]) begin : g_rw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_en) q <= wr_data[b];
      end
      assign filt_q[b] = q;
    end else begin : g_ro
      assign filt_q[b] = 1'b0;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^(wr_data & ~KEEP);

  // The secure level-2 bit is hidden while that level is switched off.
  assign rd_val = s2_live ? filt_q : (filt_q & ~S2_MASK);

endmodule

// File: rtl/pfc_level_gate.sv
module pfc_level_gate #(
  parameter bit HAS_LVL2     = 1'b1,
  parameter bit HAS_LVL3     = 1'b1,
  parameter bit HAS_SEC_LVL2 = 1'b1
) (
  input  logic [pfc_pkg::FW-1:0] filt,
  input  logic [1:0]             lvl,
  input  logic                   sec,
  input  logic                   s2_live,
  input  logic                   run,
  output logic                   permit,
  output logic                   tick
);
  import pfc_pkg::*;

  assign permit = level_permits(filt, lvl, sec, s2_live,
                                HAS_LVL2, HAS_LVL3, HAS_SEC_LVL2);
  assign tick   = run & permit;

endmodule

// File: rtl/pfc_counter.sv
module pfc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + ONE;
  end

  assign wrap_evt = tick & (&count);

endmodule

// File: rtl/pfc_dbg_port.sv
module pfc_dbg_port #(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] FILT_OFS = ADDR_W'('h47C)
) (
  input  logic                   clk,
  input  logic                   dbg_rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [pfc_pkg::FW-1:0] wdata,
  input  logic                   pwr_on,
  input  logic                   dbl_lock,
  input  logic                   os_lock,
  input  logic                   allow,
  input  logic                   sw_lock,
  input  logic [pfc_pkg::FW-1:0] rd_val,
  output logic                   wr_en,
  output logic [pfc_pkg::FW-1:0] wr_data,
  output logic                   fault,
  output logic                   ack,
  output logic [1:0]             resp,
  output logic [pfc_pkg::FW-1:0] rdata
);
  import pfc_pkg::*;

  logic gate_open;
  logic hit;

  assign gate_open = pwr_on & ~dbl_lock & ~os_lock & allow;
  assign hit       = (addr == FILT_OFS);
  assign fault     = req & ~(gate_open & hit);
  assign wr_en     = req & we & gate_open & hit & ~sw_lock;
  assign wr_data   = wdata;

  always_ff @(posedge clk or negedge dbg_rst_n) begin
    if (!dbg_rst_n) begin
      ack   <= 1'b0;
      resp  <= RSP_OK;
      rdata <= '0;
    end else begin
      ack   <= req;
      resp  <= fault ? RSP_ERR : RSP_OK;
      rdata <= (req & ~we & ~fault) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/pfc_cycle_counter.sv
module pfc_cycle_counter #(
  parameter int CNT_W        = 64,
  parameter int ADDR_W       = 12,
  parameter bit HAS_LVL2     = 1'b1,
  parameter bit HAS_LVL3     = 1'b1,
  parameter bit HAS_SEC_LVL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_rst_n,
  input  logic              count_en,
  input  logic [1:0]        cur_lvl,
  input  logic              cur_secure,
  input  logic              sec_lvl2_on,
  input  logic              core_pwr_on,
  input  logic              dbl_lock,
  input  logic              os_lock,
  input  logic              ext_allow,
  input  logic              sw_lock,
  input  logic              dbg_req,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [31:0]       dbg_wdata,
  output logic              dbg_ack,
  output logic [1:0]        dbg_resp,
  output logic [31:0]       dbg_rdata,
  output logic [CNT_W-1:0]  cycle_count
);
  import pfc_pkg::*;

  localparam logic [ADDR_W-1:0] FILT_OFS = ADDR_W'('h47C);

  // Named internal events, observed by the bound checker.
  logic [FW-1:0] filt_q;
  logic [FW-1:0] filt_rd;
  logic [FW-1:0] wr_data;
  logic          wr_accept;
  logic          acc_fault;
  logic          lvl_permit;
  logic          cnt_tick;
  logic          wrap_evt;

  pfc_dbg_port #(.ADDR_W(ADDR_W), .FILT_OFS(FILT_OFS)) u_port (
    .clk      (clk),
    .dbg_rst_n(dbg_rst_n),
    .req      (dbg_req),
    .we       (dbg_we),
    .addr     (dbg_addr),
    .wdata    (dbg_wdata),
    .pwr_on   (core_pwr_on),
    .dbl_lock (dbl_lock),
    .os_lock  (os_lock),
    .allow    (ext_allow),
    .sw_lock  (sw_lock),
    .rd_val   (filt_rd),
    .wr_en    (wr_accept),
    .wr_data  (wr_data),
    .fault    (acc_fault),
    .ack      (dbg_ack),
    .resp     (dbg_resp),
    .rdata    (dbg_rdata)
  );

  pfc_filter_reg #(.HAS_LVL2(HAS_LVL2), .HAS_LVL3(HAS_LVL3),
                   .HAS_SEC_LVL2(HAS_SEC_LVL2)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_accept),
    .wr_data(wr_data),
    .s2_live(sec_lvl2_on),
    .filt_q (filt_q),
    .rd_val (filt_rd)
  );

  pfc_level_gate #(.HAS_LVL2(HAS_LVL2), .HAS_LVL3(HAS_LVL3),
                   .HAS_SEC_LVL2(HAS_SEC_LVL2)) u_gate (
    .filt   (filt_q),
    .lvl    (cur_lvl),
    .sec    (cur_secure),
    .s2_live(sec_lvl2_on),
    .run    (count_en),
    .permit (lvl_permit),
    .tick   (cnt_tick)
  );

  pfc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .count   (cycle_count),
    .wrap_evt(wrap_evt)
  );

endmodule

// File: rtl/pfc_cycle_counter_chk.sv
module pfc_cycle_counter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_rst_n,
  input logic             count_en,
  input logic [1:0]       cur_lvl,
  input logic             cnt_tick,
  input logic             wrap_evt,
  input logic [CNT_W-1:0] cycle_count,
  input logic [31:0]      filt_q,
  input logic             dbg_req,
  input logic             dbg_we,
  input logic             sw_lock,
  input logic             acc_fault,
  input logic             dbg_ack,
  input logic [1:0]       dbg_resp,
  input logic [31:0]      dbg_rdata
);
  localparam logic [31:0] RSVD = 32'h02FF_FFFF;

  // R1: a permitted cycle adds exactly one
  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |=> cycle_count == CNT_W'($past(cycle_count) + CNT_W'(1)));

  // R1: a cycle that is not permitted holds the count
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(cycle_count));

  // R2: global enable low freezes the count
  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(cycle_count));

  // R7: level 3 with unequal control bits does not count
  p_l3_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && cur_lvl == 2'd3 && filt_q[26] != filt_q[31]) |=> $stable(cycle_count));

  // R8: reserved bits never read as one
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    dbg_ack |-> (dbg_rdata & RSVD) == 32'h0);

  // R9: a faulted request ends in an error response
  p_fault_err_r9: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    acc_fault |=> dbg_ack && dbg_resp == 2'b10);

  // R10: a write under the software lock leaves the filter unchanged
  p_swlock_ro_r10: assert property (@(posedge clk) disable iff (!rst_n || !dbg_rst_n)
    (dbg_req && dbg_we && sw_lock) |=> $stable(filt_q));

  // R11: the acknowledge follows each request by one cycle
  p_ack_next_r11: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    dbg_req |=> dbg_ack);

  // R11: no acknowledge without a request
  p_ack_idle_r11: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    !dbg_req |=> !dbg_ack);

  // R13: a wrap event returns the count to zero
  p_wrap_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cycle_count == '0);

endmodule

bind pfc_cycle_counter pfc_cycle_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_rst_n  (dbg_rst_n),
  .count_en   (count_en),
  .cur_lvl    (cur_lvl),
  .cnt_tick   (cnt_tick),
  .wrap_evt   (wrap_evt),
  .cycle_count(cycle_count),
  .filt_q     (filt_q),
  .dbg_req    (dbg_req),
  .dbg_we     (dbg_we),
  .sw_lock    (sw_lock),
  .acc_fault  (acc_fault),
  .dbg_ack    (dbg_ack),
  .dbg_resp   (dbg_resp),
  .dbg_rdata  (dbg_rdata)
);

// File: tb/pfc_cycle_counter_test.sv
`timescale 1ns/100ps
module pfc_cycle_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, dbg_rst_n = 1'b0, n_rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic [1:0]  cur_lvl = 2'd0;
  logic        cur_secure = 1'b1, sec_lvl2_on = 1'b1;
  logic        core_pwr_on = 1'b1, dbl_lock = 1'b0, os_lock = 1'b0;
  logic        ext_allow = 1'b1, sw_lock = 1'b0;
  logic        dbg_req = 1'b0, n_req = 1'b0, dbg_we = 1'b0;
  logic [11:0] dbg_addr = 12'h47C;
  logic [31:0] dbg_wdata = 32'h0;
  logic        dbg_ack, n_ack;
  logic [1:0]  dbg_resp, n_resp;
  logic [31:0] dbg_rdata, n_rdata;
  logic [63:0] cycle_count;
  logic [7:0]  n_count;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [11:0] OFS = 12'h47C;

  always #2.5 clk = ~clk;

  pfc_cycle_counter uut (
    .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .count_en(count_en),
    .cur_lvl(cur_lvl), .cur_secure(cur_secure), .sec_lvl2_on(sec_lvl2_on),
    .core_pwr_on(core_pwr_on), .dbl_lock(dbl_lock), .os_lock(os_lock),
    .ext_allow(ext_allow), .sw_lock(sw_lock), .dbg_req(dbg_req), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_ack(dbg_ack),
    .dbg_resp(dbg_resp), .dbg_rdata(dbg_rdata), .cycle_count(cycle_count)
  );

  // Narrow variant: 8-bit count, no level 2, no level 3.
  pfc_cycle_counter #(.CNT_W(8), .HAS_LVL2(1'b0), .HAS_LVL3(1'b0),
                      .HAS_SEC_LVL2(1'b0)) uut_narrow (
    .clk(clk), .rst_n(n_rst_n), .dbg_rst_n(dbg_rst_n), .count_en(count_en),
    .cur_lvl(cur_lvl), .cur_secure(cur_secure), .sec_lvl2_on(sec_lvl2_on),
    .core_pwr_on(core_pwr_on), .dbl_lock(dbl_lock), .os_lock(os_lock),
    .ext_allow(ext_allow), .sw_lock(sw_lock), .dbg_req(n_req), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_ack(n_ack),
    .dbg_resp(n_resp), .dbg_rdata(n_rdata), .cycle_count(n_count)
  );

  typedef struct packed {
    logic [31:0] f;
    logic [1:0]  lvl;
    logic        sec;
    logic        s2;
    logic        en;
    logic        cnt;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{32'h0000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1},  // R3
    '{32'h4000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0},  // R3
    '{32'h8000_0000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},  // R3
    '{32'h4000_0000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1},  // R3
    '{32'h0000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1},  // R4
    '{32'h2000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    '{32'hA000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1},  // R4
    '{32'h8000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    '{32'h1000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
    '{32'h5000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},  // R4
    '{32'h0000_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0},  // R5
    '{32'h0800_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1},  // R5
    '{32'h0100_0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},  // R6
    '{32'h0900_0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0},  // R6
    '{32'h0800_0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},  // R6
    '{32'h0100_0000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R6
    '{32'h0000_0000, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},  // R7
    '{32'h0400_0000, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},  // R7
    '{32'h8400_0000, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1},  // R7
    '{32'h8000_0000, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},  // R7
    '{32'h0000_0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},  // R2
    '{32'hFFFF_FFFF, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}   // R8
  };
  localparam int RQ [NV] = '{3,3,3,3,4,4,4,4,4,4,5,5,6,6,6,6,7,7,7,7,2,8};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access; starts and ends at a falling edge.
  task automatic dbg_op(input logic nar, input logic we, input logic [11:0] a,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic [1:0] rs, output logic ak);
    @(negedge clk);
    if (nar) n_req = 1'b1; else dbg_req = 1'b1;
    dbg_we = we; dbg_addr = a; dbg_wdata = wd;
    @(negedge clk);
    ak = nar ? n_ack : dbg_ack;
    rd = nar ? n_rdata : dbg_rdata;
    rs = nar ? n_resp : dbg_resp;
    dbg_req = 1'b0; n_req = 1'b0; dbg_we = 1'b0; dbg_addr = OFS;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [1:0]  rs;
    logic        ak;
    logic [63:0] c0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1; dbg_rst_n = 1'b1; n_rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 count after reset", cycle_count, 64'h0);
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R1 filter after reset", {32'h0, rd}, 64'h0);
    chk("R1 read response", {62'h0, rs}, 64'h0);

    // Table of level/state/filter vectors
    for (int i = 0; i < NV; i++) begin
      dbg_op(1'b0, 1'b1, OFS, VT[i].f, rd, rs, ak);
      cur_lvl = VT[i].lvl; cur_secure = VT[i].sec;
      sec_lvl2_on = VT[i].s2; count_en = VT[i].en;
      c0 = cycle_count;
      repeat (4) @(posedge clk);
      @(negedge clk);
      count_en = 1'b0;
      chk($sformatf("R%0d vector %0d delta", RQ[i], i), cycle_count - c0,
          VT[i].cnt ? 64'd4 : 64'd0);
    end
    sec_lvl2_on = 1'b1;

    // R8: read-back masks
    dbg_op(1'b0, 1'b1, OFS, 32'hFFFF_FFFF, rd, rs, ak);
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R8 full read-back", {32'h0, rd}, {32'h0, 32'hFD00_0000});
    sec_lvl2_on = 1'b0;
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R6 bit 24 hidden when secure level 2 off", {32'h0, rd}, {32'h0, 32'hFC00_0000});
    sec_lvl2_on = 1'b1;
    dbg_op(1'b1, 1'b1, OFS, 32'hFFFF_FFFF, rd, rs, ak);
    dbg_op(1'b1, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R8 narrow variant read-back", {32'h0, rd}, {32'h0, 32'hC000_0000});

    // R10: software lock makes the filter read-only
    dbg_op(1'b0, 1'b1, OFS, 32'h0400_0000, rd, rs, ak);
    sw_lock = 1'b1;
    dbg_op(1'b0, 1'b1, OFS, 32'h8000_0000, rd, rs, ak);
    chk("R10 locked write response", {62'h0, rs}, 64'h0);
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R10 locked read value", {32'h0, rd}, {32'h0, 32'h0400_0000});
    sw_lock = 1'b0;

    // R9: error conditions
    core_pwr_on = 1'b0;
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R9 unpowered resp", {62'h0, rs}, 64'h2);
    chk("R9 unpowered data", {32'h0, rd}, 64'h0);
    core_pwr_on = 1'b1; dbl_lock = 1'b1;
    dbg_op(1'b0, 1'b1, OFS, 32'h0, rd, rs, ak);
    chk("R9 double lock resp", {62'h0, rs}, 64'h2);
    dbl_lock = 1'b0; os_lock = 1'b1;
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R9 os lock resp", {62'h0, rs}, 64'h2);
    os_lock = 1'b0; ext_allow = 1'b0;
    dbg_op(1'b0, 1'b1, OFS, 32'h0, rd, rs, ak);
    chk("R9 access refused resp", {62'h0, rs}, 64'h2);
    ext_allow = 1'b1;
    dbg_op(1'b0, 1'b1, 12'h478, 32'h0, rd, rs, ak);
    chk("R9 wrong offset resp", {62'h0, rs}, 64'h2);
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R9 filter untouched by faulted writes", {32'h0, rd}, {32'h0, 32'h0400_0000});

    // R11: response timing and write-to-effect latency
    dbg_op(1'b0, 1'b1, OFS, 32'h0, rd, rs, ak);
    cur_lvl = 2'd0; cur_secure = 1'b1; count_en = 1'b1;
    c0 = cycle_count;
    dbg_req = 1'b1; dbg_we = 1'b1; dbg_wdata = 32'h4000_0000;
    @(negedge clk);
    chk("R11 ack one cycle after request", {63'h0, dbg_ack}, 64'h1);
    chk("R11 storing cycle uses old filter", cycle_count - c0, 64'd1);
    dbg_req = 1'b0; dbg_we = 1'b0;
    @(negedge clk);
    chk("R11 ack drops without request", {63'h0, dbg_ack}, 64'h0);
    repeat (2) @(negedge clk);
    chk("R11 new filter blocks later cycles", cycle_count - c0, 64'd1);
    count_en = 1'b0;

    // R12: debug reset leaves filter and count alone
    c0 = cycle_count;
    dbg_rst_n = 1'b0;
    @(negedge clk);
    dbg_rst_n = 1'b1;
    @(negedge clk);
    chk("R12 count kept", cycle_count, c0);
    dbg_op(1'b0, 1'b0, OFS, 32'h0, rd, rs, ak);
    chk("R12 filter kept", {32'h0, rd}, {32'h0, 32'h4000_0000});

    // R13: wrap on the narrow variant
    n_rst_n = 1'b0;
    @(negedge clk);
    n_rst_n = 1'b1;
    cur_lvl = 2'd0; cur_secure = 1'b1; count_en = 1'b1;
    repeat (255) @(posedge clk);
    @(negedge clk);
    chk("R13 narrow reaches all ones", {56'h0, n_count}, 64'hFF);
    @(negedge clk);
    chk("R13 narrow wraps to zero", {56'h0, n_count}, 64'h0);
    count_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule